// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block sits between the interrupt sources of a system and a processor core. Three kinds of event reach it as one-cycle strobes: a reset request, a non-maskable request and a new maskable interrupt level. Each event is recorded in its own pending record. The core marks every instruction boundary with a strobe. At each such boundary the block serves at most one pending record, chosen by fixed priority, and answers with a one-cycle exception pulse. For the maskable level it also keeps the core's hardware-interrupt pending field (the cause IP bits) up to date.

A maskable level is delivered only while the core's global interrupt enable is set and the level shares at least one bit with the interrupt mask. A blocked level is not dropped. It stays pending and is tried again at every later boundary until it gets through or is withdrawn. A level of zero is a withdrawal event of its own, and it clears the cause IP bits when it is served.

Top module: `intr_dispatch`

## Requirements
- R1: A synchronous reset (`rst` high) clears all pending records, both exception outputs and `cause_ip`. After reset, a boundary with no event produces no exception and leaves `cause_ip` at zero.
- R2: A `req_rst` strobe makes a request pending. At the next cycle with `inst_done` high the request is served: `exc_nmi_reset` is high in the cycle after that edge. The request is then cleared, so it produces no second pulse.
- R3: A `req_nmi` strobe is served in the same way, with the same `exc_nmi_reset` output, and is cleared once served.
- R4: Priority is fixed: reset first, then non-maskable, then the maskable level. Only one record is served per boundary, and the others wait for later boundaries.
- R5: When a nonzero pending level is evaluated, `cause_ip` takes the level value, bit i for interrupt line i. This happens whether or not the level is delivered, and the value stays after delivery.
- R6: `exc_int` pulses only when `sr_ie` is 1 and (level & `sr_im`) is nonzero at the evaluating boundary. Bit i of `sr_im` enables bit i of the level. A delivered level is no longer pending.
- R7: A level blocked by `sr_ie` or `sr_im` stays pending and is evaluated again at every later boundary until it is delivered or replaced.
- R8: An `irq_lvl_evt` carrying the value 0 is a withdrawal. At its evaluating boundary `cause_ip` becomes 0, no `exc_int` is raised, and the level is no longer pending.
- R9: In a cycle where `inst_done` is low, no record is served: the exception outputs stay low and `cause_ip` keeps its value in the next cycle.
- R10: A level event in the same cycle as a boundary replaces the pending level after that boundary has evaluated the old one. The new value is evaluated at the next boundary.
- R11: Exception outputs are single-cycle pulses, and `exc_nmi_reset` and `exc_int` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_rst | input | 1 | Reset request strobe |
| req_nmi | input | 1 | Non-maskable request strobe |
| irq_lvl_evt | input | 1 | Strobe: new maskable level on irq_lvl |
| irq_lvl | input | IP_W | Maskable level value (0 = withdraw) |
| sr_ie | input | 1 | Current global interrupt enable from the status register |
| sr_im | input | IP_W | Interrupt mask field from the status register |
| inst_done | input | 1 | Instruction boundary strobe |
| exc_nmi_reset | output | 1 | Reset/NMI exception request pulse |
| exc_int | output | 1 | Maskable interrupt exception request pulse |
| cause_ip | output | IP_W | Hardware-interrupt pending bits of the cause register |

## Verification
If a pending record is stuck or lost, the effect shows at the first boundary after the event that should have changed it. A lost record shows as a missing `exc_nmi_reset` or `exc_int` pulse one cycle after that `inst_done` edge. A stuck record shows as an extra pulse at the following boundary. A wrong priority or mask decision shows in the same cycle as the pulse, as the wrong output, or as `cause_ip` holding a value other than the last evaluated level. Because a blocked level is retried at every boundary, a record dropped by mistake shows up as a delivery that never arrives once the mask opens. The bench therefore compares all three outputs on every cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
  // State of the maskable level record
  typedef enum logic [1:0] {
    LV_IDLE  = 2'd0,
    LV_ARMED = 2'd1,
    LV_EOI   = 2'd2
  } lvl_st_e;

  // Which record a boundary serves
  typedef enum logic [1:0] {
    SRV_NONE  = 2'd0,
    SRV_RESET = 2'd1,
    SRV_NMI   = 2'd2,
    SRV_LEVEL = 2'd3
  } srv_e;
endpackage

// File: rtl/intr_evt_latch.sv
module intr_evt_latch
  import intr_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_rst,
  input  logic            req_nmi,
  input  logic            irq_lvl_evt,
  input  logic [IP_W-1:0] irq_lvl,
  input  srv_e            srv,
  input  logic            lvl_retire,
  output logic            rst_pend,
  output logic            nmi_pend,
  output lvl_st_e         lvl_st,
  output logic [IP_W-1:0] lvl_val
);
  // A zero level is recorded as a withdrawal, not as "no event"
  function automatic lvl_st_e classify(input logic [IP_W-1:0] v);
    return (v == '0) ? LV_EOI : LV_ARMED;
  endfunction

  logic srv_rst, srv_nmi;
  assign srv_rst = (srv == SRV_RESET);
  assign srv_nmi = (srv == SRV_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend <= 1'b0;
      nmi_pend <= 1'b0;
      lvl_st   <= LV_IDLE;
      lvl_val  <= '0;
    end else begin
      // a new strobe wins over the clear of a record served this cycle
      rst_pend <= req_rst | (rst_pend & ~srv_rst);
      nmi_pend <= req_nmi | (nmi_pend & ~srv_nmi);
      if (irq_lvl_evt) begin
        lvl_st  <= classify(irq_lvl);
        lvl_val <= irq_lvl;
      end else if (lvl_retire) begin
        lvl_st  <= LV_IDLE;
      end
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input  logic            inst_done,
  input  logic            rst_pend,
  input  logic            nmi_pend,
  input  lvl_st_e         lvl_st,
  input  logic [IP_W-1:0] lvl_val,
  input  logic            sr_ie,
  input  logic [IP_W-1:0] sr_im,
  output srv_e            srv,
  output logic            fire_nr,
  output logic            fire_int,
  output logic            cause_wr,
  output logic [IP_W-1:0] cause_nxt,
  output logic            lvl_retire
);
  function automatic logic unmasked(input logic ie,
                                    input logic [IP_W-1:0] lvl,
                                    input logic [IP_W-1:0] im);
    return ie && ((lvl & im) != '0);
  endfunction

  function automatic srv_e pick(input logic done, input logic r,
                                input logic n, input lvl_st_e s);
    if (!done)          return SRV_NONE;
    if (r)              return SRV_RESET;
    if (n)              return SRV_NMI;
    if (s != LV_IDLE)   return SRV_LEVEL;
    return SRV_NONE;
  endfunction

  logic lvl_eval, lvl_hit;

  always_comb begin
    srv        = pick(inst_done, rst_pend, nmi_pend, lvl_st);
    lvl_eval   = (srv == SRV_LEVEL);
    lvl_hit    = (lvl_st == LV_ARMED) && unmasked(sr_ie, lvl_val, sr_im);
    fire_nr    = (srv == SRV_RESET) || (srv == SRV_NMI);
    fire_int   = lvl_eval && lvl_hit;
    cause_wr   = lvl_eval;
    cause_nxt  = (lvl_st == LV_ARMED) ? lvl_val : '0;
    lvl_retire = lvl_eval && ((lvl_st == LV_EOI) || lvl_hit);
  end
endmodule

// File: rtl/intr_out_reg.sv
module intr_out_reg #(
  parameter int unsigned IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire_nr,
  input  logic            fire_int,
  input  logic            cause_wr,
  input  logic [IP_W-1:0] cause_nxt,
  output logic            exc_nmi_reset,
  output logic            exc_int,
  output logic [IP_W-1:0] cause_ip
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_nmi_reset <= 1'b0;
      exc_int       <= 1'b0;
    end else begin
      exc_nmi_reset <= fire_nr;
      exc_int       <= fire_int;
    end
  end

  // one flop per cause bit; bit i follows interrupt line i
  for (genvar i = 0; i < IP_W; i++) begin : g_ip
    always_ff @(posedge clk) begin
      if (rst)           cause_ip[i] <= 1'b0;
      else if (cause_wr) cause_ip[i] <= cause_nxt[i];
    end
  end
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
  import intr_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_rst,
  input  logic            req_nmi,
  input  logic            irq_lvl_evt,
  input  logic [IP_W-1:0] irq_lvl,
  input  logic            sr_ie,
  input  logic [IP_W-1:0] sr_im,
  input  logic            inst_done,
  output logic            exc_nmi_reset,
  output logic            exc_int,
  output logic [IP_W-1:0] cause_ip
);
  logic            rst_pend, nmi_pend;
  lvl_st_e         lvl_st;
  logic [IP_W-1:0] lvl_val;
  srv_e            srv;
  logic            fire_nr, fire_int, cause_wr, lvl_retire;
  logic [IP_W-1:0] cause_nxt;

  intr_evt_latch #(.IP_W(IP_W)) u_latch (
    .clk(clk), .rst(rst), .req_rst(req_rst), .req_nmi(req_nmi),
    .irq_lvl_evt(irq_lvl_evt), .irq_lvl(irq_lvl), .srv(srv),
    .lvl_retire(lvl_retire), .rst_pend(rst_pend), .nmi_pend(nmi_pend),
    .lvl_st(lvl_st), .lvl_val(lvl_val)
  );

  intr_arbiter #(.IP_W(IP_W)) u_arb (
    .inst_done(inst_done), .rst_pend(rst_pend), .nmi_pend(nmi_pend),
    .lvl_st(lvl_st), .lvl_val(lvl_val), .sr_ie(sr_ie), .sr_im(sr_im),
    .srv(srv), .fire_nr(fire_nr), .fire_int(fire_int),
    .cause_wr(cause_wr), .cause_nxt(cause_nxt), .lvl_retire(lvl_retire)
  );

  intr_out_reg #(.IP_W(IP_W)) u_out (
    .clk(clk), .rst(rst), .fire_nr(fire_nr), .fire_int(fire_int),
    .cause_wr(cause_wr), .cause_nxt(cause_nxt),
    .exc_nmi_reset(exc_nmi_reset), .exc_int(exc_int), .cause_ip(cause_ip)
  );
endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk
  import intr_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            inst_done,
  input logic            sr_ie,
  input logic            rst_pend,
  input logic            nmi_pend,
  input lvl_st_e         lvl_st,
  input logic            exc_nmi_reset,
  input logic            exc_int,
  input logic [IP_W-1:0] cause_ip
);
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(exc_nmi_reset && exc_int)); // R11
  AST_NO_BOUNDARY_NO_EXC: assert property (@(posedge clk) disable iff (rst)
    !inst_done |=> (!exc_nmi_reset && !exc_int)); // R9
  AST_NO_BOUNDARY_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inst_done |=> $stable(cause_ip)); // R9
  AST_RST_SERVED: assert property (@(posedge clk) disable iff (rst)
    (inst_done && rst_pend) |=> (exc_nmi_reset && !exc_int)); // R2
  AST_NMI_SERVED: assert property (@(posedge clk) disable iff (rst)
    (inst_done && nmi_pend) |=> exc_nmi_reset); // R3
  AST_DISABLED_NO_INT: assert property (@(posedge clk) disable iff (rst)
    (inst_done && !sr_ie) |=> !exc_int); // R6
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (inst_done && !rst_pend && !nmi_pend && lvl_st == LV_EOI)
      |=> (cause_ip == '0 && !exc_int)); // R8
  AST_INT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    exc_int |-> (cause_ip != '0)); // R5
endmodule

bind intr_dispatch intr_dispatch_chk #(.IP_W(IP_W)) u_chk (
  .clk(clk), .rst(rst), .inst_done(inst_done), .sr_ie(sr_ie),
  .rst_pend(rst_pend), .nmi_pend(nmi_pend), .lvl_st(lvl_st),
  .exc_nmi_reset(exc_nmi_reset), .exc_int(exc_int), .cause_ip(cause_ip)
);

// File: tb/tb_intr_dispatch.sv
`timescale 1ns/1ps
module tb_intr_dispatch;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_rst = 0, req_nmi = 0, irq_lvl_evt = 0, sr_ie = 0, inst_done = 0;
  logic [W-1:0] irq_lvl = '0, sr_im = '0;
  logic         exc_nmi_reset, exc_int;
  logic [W-1:0] cause_ip;

  int total = 0;
  int bad = 0;

  // bench model of the pending records (0 idle, 1 armed, 2 withdrawn)
  bit           m_rst, m_nmi;
  int           m_st;
  logic [W-1:0] m_val, m_cause;

  always #2 clk = ~clk;

  intr_dispatch #(.IP_W(W)) dut (
    .clk(clk), .rst(rst), .req_rst(req_rst), .req_nmi(req_nmi),
    .irq_lvl_evt(irq_lvl_evt), .irq_lvl(irq_lvl), .sr_ie(sr_ie), .sr_im(sr_im),
    .inst_done(inst_done), .exc_nmi_reset(exc_nmi_reset), .exc_int(exc_int),
    .cause_ip(cause_ip)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit deliverable(input logic ie, input logic [W-1:0] v,
                                     input logic [W-1:0] m);
    for (int i = 0; i < W; i++) if (ie && v[i] && m[i]) return 1'b1;
    return 1'b0;
  endfunction

  // one cycle: drive, predict, clock, compare
  task automatic step(input bit r, input bit n, input bit le, input logic [W-1:0] lv,
                      input bit ie, input logic [W-1:0] im, input bit done,
                      input string tag);
    bit e_nr, e_int;
    req_rst = r; req_nmi = n; irq_lvl_evt = le; irq_lvl = lv;
    sr_ie = ie; sr_im = im; inst_done = done;
    e_nr = 0; e_int = 0;
    if (done) begin
      if (m_rst) begin e_nr = 1; m_rst = 0; end
      else if (m_nmi) begin e_nr = 1; m_nmi = 0; end
      else if (m_st == 2) begin m_cause = '0; m_st = 0; end
      else if (m_st == 1) begin
        m_cause = m_val;
        if (deliverable(ie, m_val, im)) begin e_int = 1; m_st = 0; end
      end
    end
    if (r) m_rst = 1;
    if (n) m_nmi = 1;
    if (le) begin m_val = lv; m_st = (lv == 0) ? 2 : 1; end
    @(posedge clk); #1;
    check({tag, " exc_nmi_reset"}, 32'(exc_nmi_reset), 32'(e_nr));
    check({tag, " exc_int"}, 32'(exc_int), 32'(e_int));
    check({tag, " cause_ip"}, 32'(cause_ip), 32'(m_cause));
    check("R11 exclusive pulses", 32'(exc_nmi_reset & exc_int), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    m_rst = 0; m_nmi = 0; m_st = 0; m_val = '0; m_cause = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset exc_nmi_reset", 32'(exc_nmi_reset), 32'd0);
    check("R1 reset exc_int", 32'(exc_int), 32'd0);
    check("R1 reset cause_ip", 32'(cause_ip), 32'd0);
    rst = 0;
    step(0,0,0,'0,1,6'h3f,1,"R1 idle boundary");

    // reset and NMI together, no boundary yet
    step(1,1,0,'0,0,'0,0,"R9 no boundary");
    step(0,0,0,'0,0,'0,0,"R9 still waiting");
    step(0,0,0,'0,0,'0,1,"R2 reset served");
    step(0,0,0,'0,0,'0,1,"R3 nmi served");
    step(0,0,0,'0,0,'0,1,"R4 nothing left");

    // blocked level, retried, then delivered
    step(0,0,1,6'b000101,0,6'h3f,0,"R5 arm level");
    step(0,0,0,'0,0,6'h3f,1,"R5 cause written while blocked");
    step(0,0,0,'0,1,6'b000010,1,"R7 retried masked");
    step(0,0,0,'0,1,6'b000100,1,"R6 delivered");
    step(0,0,0,'0,1,6'h3f,1,"R6 not pending after delivery");

    // withdrawal
    step(0,0,1,6'b000011,1,'0,0,"R8 arm blocked");
    step(0,0,0,'0,1,'0,1,"R7 blocked sets cause");
    step(0,0,1,'0,1,'0,0,"R8 withdraw event");
    step(0,0,0,'0,1,6'h3f,1,"R8 cause cleared");
    step(0,0,0,'0,1,6'h3f,1,"R8 nothing pending");

    // same-cycle replacement
    step(0,0,1,6'b000010,1,'0,0,"R10 arm old");
    step(0,0,1,6'b010000,1,6'b000010,1,"R10 old evaluated");
    step(0,0,0,'0,1,6'b010000,1,"R10 new evaluated");

    // reset ahead of a deliverable level
    step(1,0,1,6'b100000,1,6'h3f,0,"R4 arm both");
    step(0,0,0,'0,1,6'h3f,1,"R4 reset first");
    step(0,0,0,'0,1,6'h3f,1,"R4 level next");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      bit r, n, le, ie, d;
      logic [W-1:0] lv, im;
      r  = ($urandom % 16) == 0;
      n  = ($urandom % 12) == 0;
      le = ($urandom % 6) == 0;
      lv = (($urandom % 4) == 0) ? '0 : W'($urandom);
      ie = ($urandom % 3) != 0;
      im = W'($urandom);
      d  = ($urandom % 2) == 0;
      step(r, n, le, lv, ie, im, d, "R4 R5 R6 R7 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule